// File: doc/BRIEF.md
# SPI Master Burst Shift Engine

This block runs one SPI master exchange made of 8-bit words. Software first loads a control word and then sets its start bit. The engine takes a total byte count and a transmit byte count. It pulls the first transmit-count bytes from an external first-word-fall-through transmit FIFO. It then sends filler bytes of 0x00 until the full burst has been clocked. Every byte captured from the slave is handed to an external receive FIFO, unless the discard option removes it.

Serial clock timing comes from an external divider. That divider supplies a one-cycle `tick`, and each tick advances the serial clock by half a period. The engine does the following:
- drives one of four chip-select lines, either automatically or by hand;
- supports all four clock polarity and phase combinations;
- shifts either MSB first or LSB first.

When the last byte has been clocked, the start bit clears itself and a sticky completion flag is raised.

If the transmit FIFO runs dry before the transmit count is used up, the engine waits. The serial clock stays at its idle level until data arrives.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset, all four `ss` lines are high, `sck` is low, `running` and `tc_flag` are low, and neither `txf_pop` nor `rxf_push` is asserted.
- R2: Control bit 1 sets the idle level of `sck`. When control bit 0 is clear, both sides sample on the leading edge. When it is set, both sides sample on the trailing edge. Words are 8 bits and go MSB first while control bit 12 is clear.
- R3: With control bit 12 set, both the transmitted and the received bytes are shifted LSB first.
- R4: Control bits [5:4] pick line i of `ss`. In automatic mode, only that line is driven to its active level, and only while `running` is high. Control bit 2 clear makes the lines active-low (idle high). Control bit 2 set makes them active-high (idle low).
- R5: With control bit 6 set, the selected line is driven to the value of control bit 7 whether or not an exchange runs. The other lines stay idle.
- R6: A write with bit 31 set while idle starts an exchange of `burst_cnt` bytes. The first `tx_cnt` bytes are popped from the transmit FIFO, and the remaining bytes are sent as 0x00.
- R7: With control bit 8 set, bytes received while FIFO data is being sent are not pushed to the receive FIFO. Bytes received during the filler phase are still pushed.
- R8: After the last byte, `running` falls and `tc_flag` rises on the same clock edge. `tc_flag` stays set until `tc_clr` is pulsed or a new exchange starts. If completion and `tc_clr` fall in the same cycle, the flag is set.
- R9: If the transmit FIFO is empty while transmit bytes remain, `sck` holds its idle level and no byte starts until data is present. The exchange then resumes with no lost bytes.
- R10: Control writes, including bit 31, are ignored while `running` is high. Mode, select, counts and chip select stay unchanged.
- R11: An exchange started with a zero burst count completes on the next cycle with no `sck` edges and no FIFO pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word |
| burst_cnt | input | CNT_W | Total bytes to clock, taken at start |
| tx_cnt | input | CNT_W | Bytes taken from the transmit FIFO, taken at start |
| tc_clr | input | 1 | Clears the completion flag |
| tick | input | 1 | Half serial period enable from the divider |
| txf_data | input | 8 | Head byte of the transmit FIFO |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_pop | output | 1 | Consumes the head byte of the transmit FIFO |
| rxf_data | output | 8 | Received byte |
| rxf_push | output | 1 | Writes `rxf_data` into the receive FIFO |
| running | output | 1 | Start bit; high while the exchange is in progress |
| tc_flag | output | 1 | Sticky completion status |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss | output | 4 | Chip-select lines |
| miso | input | 1 | Serial data in |

## Verification
The completion event and a software clear of `tc_flag` can land in the same cycle. A zero-length burst makes the completion cycle fall exactly one cycle after the start write, so the bench pulses `tc_clr` in that cycle and expects the flag to read set afterwards. A second collision is provoked by writing a new control word with the start bit while an exchange runs. The bench judges that collision at the ports: `ss` must not change, and the slave must capture the original byte count in the original bit order.

// File: rtl/spi_burst_engine.sv
module spi_burst_engine #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  input  logic [CNT_W-1:0] burst_cnt,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic             tc_clr,
  input  logic             tick,
  input  logic [7:0]       txf_data,
  input  logic             txf_empty,
  output logic             txf_pop,
  output logic [7:0]       rxf_data,
  output logic             rxf_push,
  output logic             running,
  output logic             tc_flag,
  output logic             sck,
  output logic             mosi,
  output logic [3:0]       ss,
  input  logic             miso
);

  logic             pha, pol, act_hi, man, man_lvl, discard, lsb;
  logic [1:0]       sel;
  logic [CNT_W-1:0] bleft, tleft;
  logic             inbyte, from_fifo;
  logic [3:0]       edge_n;
  logic [7:0]       tsh, rsh, rx_nxt;

  wire start   = cfg_we & cfg_wdata[31] & ~running;
  wire tx_more = (tleft != '0);
  wire load_ok = running & ~inbyte & (bleft != '0) & (~tx_more | ~txf_empty);
  wire fin     = running & ~inbyte & (bleft == '0);
  wire lead    = ~edge_n[0];
  wire samp    = inbyte & tick & (lead ^ pha);
  wire shft    = inbyte & tick & ~(lead ^ pha) & (edge_n != 4'd0);
  wire last    = inbyte & tick & (edge_n == 4'd15);

  assign txf_pop = load_ok & tx_more;
  assign sck     = pol ^ (inbyte & edge_n[0]);
  assign mosi    = lsb ? tsh[0] : tsh[7];

  always_comb begin
    rx_nxt = rsh;
    if (samp) rx_nxt = lsb ? {miso, rsh[7:1]} : {rsh[6:0], miso};
  end

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      if (sel == 2'(i)) ss[i] = man ? man_lvl : (running ? act_hi : ~act_hi);
      else              ss[i] = ~act_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {pha, pol, act_hi, man, man_lvl, discard, lsb} <= '0;
      sel       <= '0;
      running   <= 1'b0;
      tc_flag   <= 1'b0;
      bleft     <= '0;
      tleft     <= '0;
      inbyte    <= 1'b0;
      from_fifo <= 1'b0;
      edge_n    <= '0;
      tsh       <= '0;
      rsh       <= '0;
      rxf_data  <= '0;
      rxf_push  <= 1'b0;
    end else begin
      rxf_push <= 1'b0;
      if (cfg_we && !running) begin
        pha     <= cfg_wdata[0];
        pol     <= cfg_wdata[1];
        act_hi  <= cfg_wdata[2];
        sel     <= cfg_wdata[5:4];
        man     <= cfg_wdata[6];
        man_lvl <= cfg_wdata[7];
        discard <= cfg_wdata[8];
        lsb     <= cfg_wdata[12];
        running <= cfg_wdata[31];
        if (cfg_wdata[31]) begin
          bleft <= burst_cnt;
          tleft <= tx_cnt;
        end
      end
      if (start)       tc_flag <= 1'b0;
      else if (fin)    tc_flag <= 1'b1;
      else if (tc_clr) tc_flag <= 1'b0;
      if (fin) running <= 1'b0;
      if (load_ok) begin
        inbyte    <= 1'b1;
        edge_n    <= '0;
        from_fifo <= tx_more;
        tsh       <= tx_more ? txf_data : 8'h00;
        if (tx_more) tleft <= tleft - 1'b1;
      end
      if (inbyte && tick) edge_n <= edge_n + 4'd1;
      if (shft) tsh <= lsb ? {1'b0, tsh[7:1]} : {tsh[6:0], 1'b0};
      rsh <= rx_nxt;
      if (last) begin
        inbyte   <= 1'b0;
        bleft    <= bleft - 1'b1;
        rxf_data <= rx_nxt;
        rxf_push <= ~(discard & from_fifo);
      end
    end
  end

  a_r6_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    txf_pop |-> !txf_empty);

  a_r4_one_line_active: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ss ^ {4{~act_hi}}) <= 1);

  a_r8_flag_with_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_flag) |-> !running);

  a_r9_starved_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !inbyte && txf_empty && tx_more) |=> !inbyte);

  a_r7_discard_holds: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_push |-> !(discard && from_fifo));

  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> $stable({sel, lsb, pha, pol, act_hi}));

endmodule

// File: tb/test_spi_burst_engine.sv
module test_spi_burst_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [23:0] burst_cnt = '0, tx_cnt = '0;
  logic        tc_clr = 1'b0;
  logic        tick;
  logic [7:0]  txf_data;
  logic        txf_empty, txf_pop;
  logic [7:0]  rxf_data;
  logic        rxf_push, running, tc_flag, sck, mosi;
  logic [3:0]  ss;
  logic        miso_r = 1'b0;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  logic [1:0] tdiv = '0;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd3);

  logic [7:0] fq [0:15];
  int fq_n = 0, fq_rd = 0;
  assign txf_empty = (fq_rd >= fq_n);
  assign txf_data  = fq[fq_rd[3:0]];
  always @(posedge clk) if (txf_pop) fq_rd <= fq_rd + 1;

  logic [7:0] sl_out [0:15];
  logic [7:0] sl_cap [0:15];
  logic [7:0] rx_got [0:15];
  logic [7:0] sl_acc = '0;
  int sl_pos = 0, sl_nb = 0, sl_ncap = 0, rx_n = 0, sck_tog = 0;
  bit m_lsb = 0, m_pha = 0, m_pol = 0;

  function automatic logic sl_bit(input int k);
    logic [7:0] b;
    if (k < 0 || k >= 128) return 1'b0;
    b = sl_out[k / 8];
    return m_lsb ? b[k % 8] : b[7 - (k % 8)];
  endfunction

  always @(sck) begin
    sck_tog = sck_tog + 1;
    if (running) begin
      if ((sck != m_pol) ^ m_pha) begin
        sl_acc = m_lsb ? {mosi, sl_acc[7:1]} : {sl_acc[6:0], mosi};
        sl_nb = sl_nb + 1;
        if (sl_nb == 8) begin
          sl_cap[sl_ncap[3:0]] = sl_acc;
          sl_ncap = sl_ncap + 1;
          sl_nb = 0;
        end
      end else begin
        sl_pos = sl_pos + 1;
        miso_r = sl_bit(sl_pos);
      end
    end
  end

  always @(negedge clk) if (rxf_push) begin
    rx_got[rx_n[3:0]] = rxf_data;
    rx_n = rx_n + 1;
  end

  spi_burst_engine i_spi_burst_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .burst_cnt(burst_cnt), .tx_cnt(tx_cnt), .tc_clr(tc_clr), .tick(tick),
    .txf_data(txf_data), .txf_empty(txf_empty), .txf_pop(txf_pop),
    .rxf_data(rxf_data), .rxf_push(rxf_push), .running(running),
    .tc_flag(tc_flag), .sck(sck), .mosi(mosi), .ss(ss), .miso(miso_r));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prep(input logic [31:0] cfg, input int nfifo);
    for (int i = 0; i < 16; i++) begin
      fq[i] = 8'hC3 ^ 8'(i * 29);
      sl_out[i] = 8'h5A + 8'(i * 17);
      sl_cap[i] = '0;
      rx_got[i] = '0;
    end
    fq_n = nfifo; fq_rd = 0;
    m_pha = cfg[0]; m_pol = cfg[1]; m_lsb = cfg[12];
    sl_pos = m_pha ? -1 : 0;
    miso_r = sl_bit(sl_pos);
    sl_nb = 0; sl_ncap = 0; rx_n = 0; sl_acc = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && running; i++) @(negedge clk);
  endtask

  task automatic run_burst(input logic [31:0] cfg, input int blen, input int tlen);
    prep(cfg, tlen);
    burst_cnt = 24'(blen); tx_cnt = 24'(tlen);
    cfg_write(cfg);
    cfg_write(cfg | 32'h8000_0000);
    wait_idle();
  endtask

  task automatic t_reset();
    chk(ss == 4'hF, "R1", "ss", ss, 4'hF);
    chk(sck == 1'b0 && running == 1'b0 && tc_flag == 1'b0, "R1", "sck/run/tc",
        {sck, running, tc_flag}, 0);
    chk(!txf_pop && !rxf_push, "R1", "pop/push", {txf_pop, rxf_push}, 0);
  endtask

  task automatic t_mode(input bit p, input bit h, input bit l);
    logic [31:0] cfg;
    string rq;
    cfg = {19'd0, l, 10'd0, p, h};
    rq = l ? "R3" : "R2";
    run_burst(cfg, 3, 3);
    chk(sl_ncap == 3, rq, "slave byte count", sl_ncap, 3);
    for (int i = 0; i < 3; i++) begin
      chk(sl_cap[i] == fq[i], rq, "mosi byte", sl_cap[i], fq[i]);
      chk(rx_got[i] == sl_out[i], rq, "miso byte", rx_got[i], sl_out[i]);
    end
    chk(sck == p, "R2", "sck idle level", sck, p);
    chk(!running && tc_flag, "R8", "run/tc after end", {running, tc_flag}, 1);
  endtask

  task automatic t_dummy();
    run_burst(32'h0, 4, 2);
    chk(fq_rd == 2, "R6", "fifo pops", fq_rd, 2);
    chk(sl_cap[1] == fq[1], "R6", "fifo byte", sl_cap[1], fq[1]);
    chk(sl_cap[2] == 8'h00 && sl_cap[3] == 8'h00, "R6", "filler bytes",
        {sl_cap[2], sl_cap[3]}, 0);
    chk(rx_n == 4, "R6", "rx count", rx_n, 4);
  endtask

  task automatic t_discard();
    run_burst(32'h100, 4, 2);
    chk(rx_n == 2, "R7", "rx count", rx_n, 2);
    chk(rx_got[0] == sl_out[2] && rx_got[1] == sl_out[3], "R7", "kept bytes",
        {rx_got[0], rx_got[1]}, {sl_out[2], sl_out[3]});
  endtask

  task automatic t_cs(input logic [31:0] cfg, input logic [3:0] on, input logic [3:0] off);
    prep(cfg, 2);
    burst_cnt = 24'd2; tx_cnt = 24'd2;
    cfg_write(cfg);
    chk(ss == off, "R4", "ss before start", ss, off);
    cfg_write(cfg | 32'h8000_0000);
    repeat (20) @(negedge clk);
    chk(ss == on, "R4", "ss during run", ss, on);
    wait_idle();
    chk(ss == off, "R4", "ss after run", ss, off);
  endtask

  task automatic t_manual();
    cfg_write(32'h0000_0070);
    chk(ss == 4'b0111, "R5", "manual low", ss, 4'b0111);
    cfg_write(32'h0000_00F0);
    chk(ss == 4'b1111, "R5", "manual high", ss, 4'b1111);
    cfg_write(32'h0000_00F4);
    chk(ss == 4'b1000, "R5", "manual high active-high", ss, 4'b1000);
    cfg_write(32'h0);
  endtask

  task automatic t_pause();
    int tog;
    prep(32'h2, 1);
    burst_cnt = 24'd3; tx_cnt = 24'd3;
    cfg_write(32'h2);
    cfg_write(32'h8000_0002);
    repeat (150) @(negedge clk);
    tog = sck_tog;
    repeat (100) @(negedge clk);
    chk(sck_tog == tog && sck == 1'b1, "R9", "sck held idle", sck_tog - tog, 0);
    chk(running && sl_ncap == 1, "R9", "stalled after one byte", sl_ncap, 1);
    fq_n = 3;
    wait_idle();
    chk(sl_ncap == 3 && sl_cap[1] == fq[1] && sl_cap[2] == fq[2], "R9",
        "resumed bytes", sl_ncap, 3);
  endtask

  task automatic t_ignore();
    prep(32'h0, 2);
    burst_cnt = 24'd2; tx_cnt = 24'd2;
    cfg_write(32'h0);
    cfg_write(32'h8000_0000);
    repeat (10) @(negedge clk);
    burst_cnt = 24'd5;
    cfg_write(32'h8000_1034);
    chk(ss == 4'b1110, "R10", "ss unchanged", ss, 4'b1110);
    wait_idle();
    chk(sl_ncap == 2, "R10", "byte count kept", sl_ncap, 2);
    chk(sl_cap[0] == fq[0] && sl_cap[1] == fq[1], "R10", "order kept",
        sl_cap[0], fq[0]);
  endtask

  task automatic t_zero_race();
    int tog;
    prep(32'h0, 0);
    burst_cnt = 24'd0; tx_cnt = 24'd0;
    chk(tc_flag == 1'b1, "R8", "flag set before", tc_flag, 1);
    tog = sck_tog;
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 32'h8000_0000;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(running && !tc_flag, "R8", "start clears flag", {running, tc_flag}, 2);
    tc_clr = 1'b1;
    @(negedge clk);
    tc_clr = 1'b0;
    chk(!running && tc_flag, "R8", "set wins over clear", {running, tc_flag}, 1);
    chk(sck_tog == tog && fq_rd == 0, "R11", "no edges, no pop", sck_tog - tog, 0);
    @(negedge clk);
    tc_clr = 1'b1;
    @(negedge clk);
    tc_clr = 1'b0;
    chk(!tc_flag, "R8", "clear alone", tc_flag, 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_mode(0, 0, 0);
    t_mode(0, 1, 0);
    t_mode(1, 0, 0);
    t_mode(1, 1, 0);
    t_mode(0, 0, 1);
    t_mode(1, 1, 1);
    t_dummy();
    t_discard();
    t_cs(32'h0000_0020, 4'b1011, 4'b1111);
    t_cs(32'h0000_0014, 4'b0010, 4'b0000);
    t_manual();
    t_pause();
    t_ignore();
    t_zero_race();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule